// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel Transfer Engine

This block moves a run of data items from one place in memory to another under the control of a four-word descriptor held in memory. When its request input is seen while idle, it reads the descriptor, which holds a source end pointer, a destination end pointer, a control word and one unused word. It then copies items one at a time through a memory read port and a memory write port. Both ports are valid/ready request channels. Each item address is worked out from the stored end pointer and the number of items still to move, so no running pointer is kept.

The control word gives the item sizes, the address increments, the item count and a burst length of 2^R items. At the end of each burst the engine pauses for one cycle and raises `rearb`, so an arbiter above it can grant another channel. When the count runs out, it writes the control word back with the count and mode fields cleared and pulses `done`. In ping-pong mode it then reads the control word of the other descriptor slot and switches to that slot if the slot is live. A stopped or unsupported mode, or a bus error on either port, ends the transfer with a one-cycle `err` pulse instead of `done`.

Back-pressure: once the engine raises `rd_valid` or `wr_valid`, it holds that valid and the matching address, size and data stable until the cycle in which the ready is high. Read data and the error flags are sampled only in the handshake cycle. Only one of the two ports has a request outstanding at a time.

Top module: `dma_desc_engine`

## Requirements
- R1: While reset is held, and on leaving reset, `rd_valid`, `wr_valid`, `done`, `err` and `rearb` are 0. `alt_sel` is 0, so the primary slot is selected.
- R2: When `req` is seen high while idle, the engine reads three 32-bit words at offsets 0, 4 and 8 of the selected slot. These are the source end pointer, the destination end pointer and the control word. The primary slot is at `desc_base` and the alternate slot at `desc_base`+16.
- R3: The control word is decoded as follows. Bits 31:30 are the destination increment and bits 27:26 the source increment: 0 byte, 1 halfword, 2 word, 3 none. Bits 29:28 are the destination item size and bits 25:24 the source item size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. Bits 17:14 hold R. Bits 13:4 hold the item count minus one. Bit 3 is a pass-through flag. Bits 2:0 are the mode: 0 stop, 1 basic, 2 auto, 3 ping-pong.
- R4: With r items still to move, each side's address is the end pointer minus ((r-1) shifted left by its increment code), aligned down to its item size. An increment code of 3 uses the end pointer unchanged, aligned down in the same way.
- R5: Each item is one read at the source address with the source size, followed by one write at the destination address with the destination size. The write carries the read data right-justified, with the bytes above the source size forced to 0. Exactly count+1 item writes are issued.
- R6: After every 2^R items that are not the last of the transfer, `rearb` is high for exactly one cycle. R values above 10 act as 10.
- R7: After a burst in basic or ping-pong mode, no new memory request is issued until `req` is high. In auto mode the next burst starts without `req`.
- R8: On completion the engine writes the control word back to slot offset 8, with bits 13:4 and 2:0 cleared and all other bits kept. After that write is accepted, `done` is high for one cycle.
- R9: After a ping-pong completion, the engine reads the other slot's control word. `alt_sel` toggles only if that word's mode field is not 0.
- R10: A fetched control word with mode 0 or 4 to 7 gives a one-cycle `err` pulse and no item reads or writes.
- R11: A read or write answered with its error flag set ends the transfer with an `err` pulse. No further writes are issued and `done` is not pulsed.
- R12: A request held without ready keeps its valid, address, size and data stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Transfer request / continue permission |
| desc_base | input | 32 | Address of the primary descriptor slot |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted this cycle |
| rd_addr | output | 32 | Read byte address |
| rd_size | output | 2 | Read size code (0 byte, 1 half, 2 word) |
| rd_data | input | 32 | Read data, right-justified, sampled at handshake |
| rd_err | input | 1 | Read error response, sampled at handshake |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted this cycle |
| wr_addr | output | 32 | Write byte address |
| wr_size | output | 2 | Write size code |
| wr_data | output | 32 | Write data, right-justified |
| wr_err | input | 1 | Write error response, sampled at handshake |
| rearb | output | 1 | One-cycle burst boundary marker |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle failure pulse |
| alt_sel | output | 1 | Descriptor slot in use (0 primary, 1 alternate) |

## Verification
The hardest cases to reach from the ports are the ping-pong hand-over and the basic-mode pause. For the hand-over, the second slot must be live for one completion and already stopped by the engine's own write-back for the next. The bench arms both slots in ping-pong mode, runs them one after the other, and watches `alt_sel` flip once and then stay put. For the pause, the bench waits until `rearb` is seen, withdraws `req` at once, and confirms that no read request appears until `req` returns. In auto mode the same withdrawal must not stop the transfer. A mid-transfer read error is forced by computing, from the address rule, the address of the third item and flagging an error only there.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_F_SRC,
    ST_F_DST,
    ST_F_CTL,
    ST_RD,
    ST_WR,
    ST_PAUSE,
    ST_WAIT,
    ST_WB,
    ST_PP_CHK
  } eng_state_t;

  typedef struct packed {
    logic [1:0] dinc;
    logic [1:0] dsz;
    logic [1:0] sinc;
    logic [1:0] ssz;
    logic [5:0] rsv;
    logic [3:0] arb;
    logic [9:0] cnt_m1;
    logic       nxt_burst;
    logic [2:0] mode;
  } ctl_t;

  localparam logic [2:0] MODE_STOP  = 3'd0;
  localparam logic [2:0] MODE_BASIC = 3'd1;
  localparam logic [2:0] MODE_AUTO  = 3'd2;
  localparam logic [2:0] MODE_PING  = 3'd3;
  localparam logic [1:0] SZ_WORD    = 2'd2;
  localparam logic [1:0] INC_NONE   = 2'd3;

  function automatic logic [WORD_W-1:0] lane_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    lane_mask = 32'h0000_00FF;
      2'd1:    lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 11
) (
  input  logic [AW-1:0] end_i,
  input  logic [CW-1:0] remain_i,
  input  logic [1:0]    inc_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] addr_o
);
  import dma_desc_pkg::*;

  logic [AW-1:0] span;
  logic [AW-1:0] raw;
  logic [AW-1:0] low;

  always_comb begin
    span   = AW'(remain_i - CW'(1)) << inc_i;
    raw    = (inc_i == INC_NONE) ? end_i : (end_i - span);
    low    = (AW'(1) << size_i) - AW'(1);
    addr_o = raw & ~low;
  end

endmodule

// File: rtl/dma_burst_ctr.sv
module dma_burst_ctr #(
  parameter int CW      = 11,
  parameter int MAX_LOG = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       step_i,
  input  logic [3:0] arb_i,
  output logic       last_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic [3:0]    log_w;

  always_comb begin
    log_w  = (arb_i > 4'(MAX_LOG)) ? 4'(MAX_LOG) : arb_i;
    lim    = (CW'(1) << log_w) - CW'(1);
    last_o = (cnt_q == lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= last_o ? '0 : cnt_q + CW'(1);
    end
  end

  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim) else $error("burst counter beyond limit"); // R6

endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine #(
  parameter int AW      = 32,
  parameter int MAX_LOG = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] desc_base,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_size,
  input  logic [31:0]   rd_data,
  input  logic          rd_err,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [1:0]    wr_size,
  output logic [31:0]   wr_data,
  input  logic          wr_err,
  output logic          rearb,
  output logic          done,
  output logic          err,
  output logic          alt_sel
);
  import dma_desc_pkg::*;

  localparam int CW = MAX_LOG + 1;

  eng_state_t    state_q;
  ctl_t          ctl_q;
  ctl_t          rd_ctl;
  logic [31:0]   ctl_bits;
  logic [31:0]   wb_word;
  logic [AW-1:0] src_end_q, dst_end_q;
  logic [AW-1:0] src_addr, dst_addr;
  logic [AW-1:0] slot_addr, peer_ctl_addr;
  logic [CW-1:0] rem_q;
  logic [31:0]   data_q;
  logic          alt_q, done_q, err_q;
  logic          rd_hs, wr_hs, burst_last, mode_ok;

  assign rd_hs    = rd_valid && rd_ready;
  assign wr_hs    = wr_valid && wr_ready;
  assign rd_ctl   = ctl_t'(rd_data);
  assign ctl_bits = ctl_q;
  assign wb_word  = {ctl_bits[31:14], 10'd0, ctl_q.nxt_burst, MODE_STOP};
  assign mode_ok  = (rd_ctl.mode == MODE_BASIC) || (rd_ctl.mode == MODE_AUTO) ||
                    (rd_ctl.mode == MODE_PING);

  assign slot_addr     = desc_base + (alt_q ? AW'(16) : AW'(0));
  assign peer_ctl_addr = desc_base + (alt_q ? AW'(8) : AW'(24));

  dma_addr_gen #(.AW(AW), .CW(CW)) u_src_addr (
    .end_i(src_end_q), .remain_i(rem_q), .inc_i(ctl_q.sinc),
    .size_i(ctl_q.ssz), .addr_o(src_addr)
  );

  dma_addr_gen #(.AW(AW), .CW(CW)) u_dst_addr (
    .end_i(dst_end_q), .remain_i(rem_q), .inc_i(ctl_q.dinc),
    .size_i(ctl_q.dsz), .addr_o(dst_addr)
  );

  dma_burst_ctr #(.CW(CW), .MAX_LOG(MAX_LOG)) u_burst (
    .clk(clk), .rst_n(rst_n),
    .clear_i(state_q == ST_F_CTL),
    .step_i(wr_hs && (state_q == ST_WR) && !wr_err),
    .arb_i(ctl_q.arb),
    .last_o(burst_last)
  );

  always_comb begin
    rd_valid = 1'b0;
    rd_addr  = slot_addr;
    rd_size  = SZ_WORD;
    wr_valid = 1'b0;
    wr_addr  = dst_addr;
    wr_size  = ctl_q.dsz;
    wr_data  = data_q;
    case (state_q)
      ST_F_SRC:  rd_valid = 1'b1;
      ST_F_DST:  begin rd_valid = 1'b1; rd_addr = slot_addr + AW'(4); end
      ST_F_CTL:  begin rd_valid = 1'b1; rd_addr = slot_addr + AW'(8); end
      ST_RD:     begin rd_valid = 1'b1; rd_addr = src_addr; rd_size = ctl_q.ssz; end
      ST_PP_CHK: begin rd_valid = 1'b1; rd_addr = peer_ctl_addr; end
      ST_WR:     wr_valid = 1'b1;
      ST_WB:     begin
        wr_valid = 1'b1;
        wr_addr  = slot_addr + AW'(8);
        wr_size  = SZ_WORD;
        wr_data  = wb_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ctl_q     <= '0;
      src_end_q <= '0;
      dst_end_q <= '0;
      rem_q     <= '0;
      data_q    <= '0;
      alt_q     <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (req) state_q <= ST_F_SRC;
        ST_F_SRC: if (rd_hs) begin
          if (rd_err) begin err_q <= 1'b1; state_q <= ST_IDLE; end
          else begin src_end_q <= AW'(rd_data); state_q <= ST_F_DST; end
        end
        ST_F_DST: if (rd_hs) begin
          if (rd_err) begin err_q <= 1'b1; state_q <= ST_IDLE; end
          else begin dst_end_q <= AW'(rd_data); state_q <= ST_F_CTL; end
        end
        ST_F_CTL: if (rd_hs) begin
          if (rd_err || !mode_ok) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            ctl_q   <= rd_ctl;
            rem_q   <= CW'(rd_ctl.cnt_m1) + CW'(1);
            state_q <= ST_RD;
          end
        end
        ST_RD: if (rd_hs) begin
          if (rd_err) begin err_q <= 1'b1; state_q <= ST_IDLE; end
          else begin data_q <= rd_data & lane_mask(ctl_q.ssz); state_q <= ST_WR; end
        end
        ST_WR: if (wr_hs) begin
          if (wr_err) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            rem_q <= rem_q - CW'(1);
            if (rem_q == CW'(1))  state_q <= ST_WB;
            else if (burst_last)  state_q <= ST_PAUSE;
            else                  state_q <= ST_RD;
          end
        end
        ST_PAUSE: state_q <= (ctl_q.mode == MODE_AUTO) ? ST_RD : ST_WAIT;
        ST_WAIT:  if (req) state_q <= ST_RD;
        ST_WB: if (wr_hs) begin
          if (wr_err) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            done_q  <= 1'b1;
            state_q <= (ctl_q.mode == MODE_PING) ? ST_PP_CHK : ST_IDLE;
          end
        end
        ST_PP_CHK: if (rd_hs) begin
          if (rd_err) err_q <= 1'b1;
          else if (rd_ctl.mode != MODE_STOP) alt_q <= ~alt_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rearb   = (state_q == ST_PAUSE);
  assign done    = done_q;
  assign err     = err_q;
  assign alt_sel = alt_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_size))
    else $error("read request dropped or changed"); // R12
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_size) && $stable(wr_data))
    else $error("write request dropped or changed"); // R12
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid)) else $error("both ports requesting"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R8
  AST_DONE_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)) else $error("done and err together"); // R11
  AST_REARB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rearb |-> rem_q != '0 ##1 !rearb) else $error("rearb on last item or held"); // R6
  AST_ALT_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_sel != $past(alt_sel)) |-> $past(state_q == ST_PP_CHK))
    else $error("slot switched outside ping-pong check"); // R9
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) && !req |=> !rd_valid && !wr_valid)
    else $error("request issued without permission"); // R7

endmodule

// File: tb/sim_dma_desc_engine.sv
module sim_dma_desc_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] desc_base = 32'h300;
  logic        rd_valid, wr_valid, rearb, done, err, alt_sel;
  logic        rd_ready = 1'b0, wr_ready = 1'b0;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic [31:0] rd_data = 32'd0;
  logic        rd_err = 1'b0;
  logic        wr_err = 1'b0;
  logic [1:0]  rd_size, wr_size;

  logic [7:0]  mem [0:1023];
  logic [7:0]  exp_m [0:1023];
  logic        pk_en = 1'b0;
  logic [31:0] pk_a = 32'd0, pk_d = 32'd0;
  logic        inj_on = 1'b0;
  logic [31:0] inj_addr = 32'd0;

  int cnt_wr = 0, cnt_done = 0, cnt_err = 0, cnt_rearb = 0, cyc = 0;
  int nvec = 0, nfail = 0;
  int s_wr, s_done, s_err, s_rearb;

  always #5 clk = ~clk;

  dma_desc_engine u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .desc_base(desc_base),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_data(rd_data), .rd_err(rd_err),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .wr_err(wr_err),
    .rearb(rearb), .done(done), .err(err), .alt_sel(alt_sel)
  );

  function automatic logic [9:0] ix(input logic [31:0] a);
    return a[9:0];
  endfunction

  function automatic logic [31:0] lanes(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] get32(input logic [31:0] a);
    return {mem[ix(a+3)], mem[ix(a+2)], mem[ix(a+1)], mem[ix(a)]};
  endfunction

  always @(negedge clk) begin
    rd_ready <= ($urandom % 4) != 0;
    wr_ready <= ($urandom % 4) != 0;
    rd_data  <= get32(rd_addr) & lanes(rd_size);
    rd_err   <= inj_on && rd_valid && (rd_addr == inj_addr);
  end

  always @(posedge clk) begin
    if (pk_en)
      for (int b = 0; b < 4; b++) mem[ix(pk_a + 32'(b))] <= pk_d[8*b +: 8];
    if (wr_valid && wr_ready && !wr_err) begin
      for (int b = 0; b < (1 << wr_size); b++) mem[ix(wr_addr + 32'(b))] <= wr_data[8*b +: 8];
      if (wr_addr < 32'h300) cnt_wr <= cnt_wr + 1;
    end
    if (done)  cnt_done  <= cnt_done + 1;
    if (err)   cnt_err   <= cnt_err + 1;
    if (rearb) cnt_rearb <= cnt_rearb + 1;
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      $display("FAIL watchdog: actual=%0d cycles expected=end of run", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec + 1, nfail + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic poke32(input logic [31:0] a, input logic [31:0] v);
    @(negedge clk);
    pk_en = 1'b1; pk_a = a; pk_d = v;
    for (int b = 0; b < 4; b++) exp_m[ix(a + 32'(b))] = v[8*b +: 8];
  endtask

  task automatic poke_end();
    @(negedge clk);
    pk_en = 1'b0;
  endtask

  task automatic fill();
    for (int a = 0; a < 768; a += 4) poke32(32'(a), $urandom);
    poke_end();
  endtask

  task automatic set_desc(input bit alt, input logic [31:0] se, input logic [31:0] de,
                          input logic [31:0] ctl);
    logic [31:0] b;
    b = 32'h300 + (alt ? 32'd16 : 32'd0);
    poke32(b, se); poke32(b + 4, de); poke32(b + 8, ctl); poke32(b + 12, 32'd0);
    poke_end();
  endtask

  function automatic logic [31:0] mkctl(input int dinc, input int sinc, input int sz,
                                        input int arb, input int n, input int mode);
    return (32'(dinc) << 30) | (32'(sz) << 28) | (32'(sinc) << 26) | (32'(sz) << 24) |
           (32'(arb) << 14) | (32'(n - 1) << 4) | 32'(mode);
  endfunction

  function automatic logic [31:0] end_of(input logic [31:0] start, input int n, input int inc);
    return (inc == 3) ? start : start + (32'(n) << inc) - 32'd1;
  endfunction

  function automatic logic [31:0] item_addr(input logic [31:0] e, input int inc,
                                            input int sz, input int r);
    logic [31:0] raw;
    raw = (inc == 3) ? e : e - (32'(r - 1) << inc);
    return raw & ~((32'd1 << sz) - 32'd1);
  endfunction

  task automatic model_move(input logic [31:0] se, input logic [31:0] de, input logic [31:0] ctl);
    int n;
    logic [31:0] sa, da, v;
    n = int'(ctl[13:4]) + 1;
    for (int k = 0; k < n; k++) begin
      sa = item_addr(se, int'(ctl[27:26]), int'(ctl[25:24]), n - k);
      da = item_addr(de, int'(ctl[31:30]), int'(ctl[29:28]), n - k);
      v = 32'd0;
      for (int b = 0; b < (1 << ctl[25:24]); b++) v[8*b +: 8] = exp_m[ix(sa + 32'(b))];
      for (int b = 0; b < (1 << ctl[29:28]); b++) exp_m[ix(da + 32'(b))] = v[8*b +: 8];
    end
  endtask

  function automatic int diffs();
    int d;
    d = 0;
    for (int a = 0; a < 768; a++) if (mem[a] !== exp_m[a]) d++;
    return d;
  endfunction

  task automatic snap();
    s_wr = cnt_wr; s_done = cnt_done; s_err = cnt_err; s_rearb = cnt_rearb;
  endtask

  task automatic run();
    req = 1'b1;
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (done || err) break;
    end
    req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_xfer(input logic [31:0] ctl, input logic [31:0] slot, input string tag);
    int n, blk;
    n   = int'(ctl[13:4]) + 1;
    blk = 1 << ((ctl[17:14] > 4'd10) ? 10 : int'(ctl[17:14]));
    chk(cnt_done - s_done == 1, {tag, " R8 done count"}, 32'(cnt_done - s_done), 1);
    chk(cnt_err == s_err, {tag, " R11 no err"}, 32'(cnt_err - s_err), 0);
    chk(cnt_wr - s_wr == n, {tag, " R5 item writes"}, 32'(cnt_wr - s_wr), 32'(n));
    chk(diffs() == 0, {tag, " R3 R4 R12 memory image"}, 32'(diffs()), 0);
    chk(get32(slot + 8) == (ctl & ~32'h3FF7), {tag, " R8 write-back"},
        get32(slot + 8), ctl & ~32'h3FF7);
    chk(cnt_rearb - s_rearb == (n - 1) / blk, {tag, " R6 rearb count"},
        32'(cnt_rearb - s_rearb), 32'((n - 1) / blk));
  endtask

  task automatic auto_case(input logic [31:0] ss, input logic [31:0] ds, input int dinc,
                           input int sinc, input int sz, input int arb, input int n,
                           input int mode, input string tag);
    logic [31:0] ctl, se, de;
    fill();
    ctl = mkctl(dinc, sinc, sz, arb, n, mode);
    se  = end_of(ss, n, sinc);
    de  = end_of(ds, n, dinc);
    set_desc(1'b0, se, de, ctl);
    model_move(se, de, ctl);
    snap();
    run();
    check_xfer(ctl, 32'h300, tag);
  endtask

  initial begin
    logic [31:0] c1, c2, se1, de1, se2, de2, se;
    bit          quiet;
    void'($urandom(32'd20251));
    for (int a = 0; a < 1024; a++) begin mem[a] = 8'd0; exp_m[a] = 8'd0; end

    repeat (3) @(negedge clk);
    chk(!rd_valid && !wr_valid && !done && !err && !rearb && !alt_sel, "R1 in reset",
        {26'd0, rd_valid, wr_valid, done, err, rearb, alt_sel}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_valid && !wr_valid && !done && !err && !rearb && !alt_sel, "R1 after reset",
        {26'd0, rd_valid, wr_valid, done, err, rearb, alt_sel}, 0);

    auto_case(32'h040, 32'h140, 0, 0, 0, 0, 3, 2, "R6 burst of one");
    auto_case(32'h010, 32'h110, 3, 3, 2, 15, 1024, 2, "R6 max count clamp");
    auto_case(32'h020, 32'h120, 2, 1, 1, 2, 9, 1, "R4 halfword to spread");

    for (int t = 0; t < 30; t++) begin
      int sz, si, di, n, arb, md;
      sz  = $urandom % 3;
      si  = (($urandom % 4) == 0) ? 3 : sz + ($urandom % (3 - sz));
      di  = (($urandom % 4) == 0) ? 3 : sz + ($urandom % (3 - sz));
      n   = 1 + ($urandom % 40);
      arb = $urandom % 5;
      md  = 1 + ($urandom % 2);
      auto_case(32'(($urandom % 16) * 4), 32'h100 + 32'(($urandom % 16) * 4),
                di, si, sz, arb, n, md, "random");
    end

    // basic mode: withdraw req at the first burst boundary
    fill();
    c1 = mkctl(2, 2, 2, 1, 6, 1);
    se1 = end_of(32'h000, 6, 2); de1 = end_of(32'h100, 6, 2);
    set_desc(1'b0, se1, de1, c1);
    model_move(se1, de1, c1);
    snap();
    req = 1'b1;
    for (int i = 0; i < 2000; i++) begin @(negedge clk); if (rearb) break; end
    req = 1'b0;
    quiet = 1'b1;
    repeat (20) begin @(negedge clk); if (rd_valid || wr_valid) quiet = 1'b0; end
    chk(quiet, "R7 basic holds without req", {31'd0, quiet}, 1);
    chk(cnt_wr - s_wr == 2, "R7 basic items before pause", 32'(cnt_wr - s_wr), 2);
    run();
    check_xfer(c1, 32'h300, "R7 basic resumed");

    // auto mode: withdrawing req does not stop it
    fill();
    c1 = mkctl(2, 2, 2, 1, 6, 2);
    set_desc(1'b0, se1, de1, c1);
    model_move(se1, de1, c1);
    snap();
    req = 1'b1;
    for (int i = 0; i < 2000; i++) begin @(negedge clk); if (rearb) break; end
    req = 1'b0;
    for (int i = 0; i < 2000; i++) begin @(negedge clk); if (done || err) break; end
    repeat (3) @(negedge clk);
    check_xfer(c1, 32'h300, "R7 auto continues");

    // ping-pong hand-over
    fill();
    c1 = mkctl(0, 0, 0, 3, 5, 3);
    c2 = mkctl(1, 1, 1, 0, 3, 3);
    se1 = end_of(32'h008, 5, 0); de1 = end_of(32'h180, 5, 0);
    se2 = end_of(32'h050, 3, 1); de2 = end_of(32'h1C0, 3, 1);
    set_desc(1'b0, se1, de1, c1);
    set_desc(1'b1, se2, de2, c2);
    model_move(se1, de1, c1);
    snap();
    run();
    check_xfer(c1, 32'h300, "R9 ping primary");
    repeat (40) @(negedge clk);
    chk(alt_sel == 1'b1, "R9 switch to live alternate", {31'd0, alt_sel}, 1);
    model_move(se2, de2, c2);
    snap();
    run();
    check_xfer(c2, 32'h310, "R2 alternate slot");
    repeat (40) @(negedge clk);
    chk(alt_sel == 1'b1, "R9 stay when peer stopped", {31'd0, alt_sel}, 1);

    // stop and unsupported modes on the alternate slot
    set_desc(1'b1, 32'h10, 32'h110, mkctl(2, 2, 2, 0, 4, 0));
    snap();
    run();
    chk(cnt_err - s_err == 1, "R10 stop mode err", 32'(cnt_err - s_err), 1);
    chk(cnt_wr == s_wr && cnt_done == s_done, "R10 stop mode no items",
        32'(cnt_wr - s_wr), 0);
    set_desc(1'b1, 32'h10, 32'h110, mkctl(2, 2, 2, 0, 4, 6));
    snap();
    run();
    chk(cnt_err - s_err == 1, "R10 mode 6 err", 32'(cnt_err - s_err), 1);
    chk(cnt_wr == s_wr, "R10 mode 6 no items", 32'(cnt_wr - s_wr), 0);

    // read error on the third item
    se = end_of(32'h020, 8, 2);
    set_desc(1'b1, se, end_of(32'h120, 8, 2), mkctl(2, 2, 2, 3, 8, 1));
    inj_addr = item_addr(se, 2, 2, 6);
    inj_on = 1'b1;
    snap();
    run();
    inj_on = 1'b0;
    chk(cnt_err - s_err == 1, "R11 read error flagged", 32'(cnt_err - s_err), 1);
    chk(cnt_done == s_done, "R11 no done after error", 32'(cnt_done - s_done), 0);
    chk(cnt_wr - s_wr == 2, "R11 writes stop at error", 32'(cnt_wr - s_wr), 2);
    repeat (10) @(negedge clk);
    chk(!rd_valid && !wr_valid, "R11 idle after error", {30'd0, rd_valid, wr_valid}, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule